// File: doc/BRIEF.md
# Dual-Enable Byte-Lane Static Memory Model

This block is a clocked, synthesizable stand-in for a 16-bit asynchronous static memory. It is meant for system simulation and emulation, where real tristate pins and real nanosecond delays are not wanted. Two chip selects of opposite polarity, an output enable, a write enable and two byte enables are decoded into one of four modes. The modes are standby, write, read and output-off. Writes touch only the byte lanes whose enable is low. Reads drive only those lanes. Each lane has its own output-valid flag, which takes the place of a tristate driver.

The word address has a page part and a word-in-page part. The low four bits pick one of sixteen words. The bits above them pick the page. The array depth is a parameter (a power of two, at least 16). Address bits above the depth alias onto the stored pages. The array is written at the rising clock edge and read combinationally, so a read reflects the controls and address of the same cycle. An active-low reset clears the array to zero.

Mode decoding: the mode is STANDBY when the chip is not selected or both byte enables are high. Otherwise it is WRITE when write enable is low, READ when write enable is high and output enable is low, and OUTOFF when both are high. No mode is held from cycle to cycle. The mode follows the inputs each cycle, and the only stored effect is the write at the clock edge in WRITE.

Top module: `sram_dual_enable`

## Requirements
- R1: The chip is selected only when `chip_sel_n` is 0 and `chip_sel` is 1. In any other case the mode is standby and `rdata_en` is 2'b00.
- R2: With `hi_byte_n` and `lo_byte_n` both 1, the mode is standby and `rdata_en` is 2'b00, whatever the other controls are.
- R3: `lo_byte_n` gates lane 0 (data bits 7:0, flag `rdata_en[0]`). `hi_byte_n` gates lane 1 (bits 15:8, flag `rdata_en[1]`). A flag can be 1 only while its byte enable is 0.
- R4: When the chip is selected with `wr_en_n` 0, `out_en_n` is ignored. `rdata_en` is 2'b00, and each selected lane stores its byte of `wdata` at the rising clock edge.
- R5: A lane whose byte enable is 1 during a write keeps its previous contents.
- R6: When the chip is selected with `wr_en_n` 1 and `out_en_n` 0, each selected lane drives its stored byte and raises its flag in the same cycle. This includes a read issued in the cycle right after a write to the same address.
- R7: When the chip is selected with `wr_en_n` 1 and `out_en_n` 1, `rdata_en` is 2'b00.
- R8: In standby, the write enable, address and data inputs leave the array unchanged.
- R9: Address bits 3:0 pick the word within a page and the bits above pick the page. The stored word is at index {page mod (DEPTH/16), word}, so with DEPTH=64 the addresses 0x00017 and 0x00057 reach the same word.
- R10: While `rst_n` is 0, every word of the array is cleared to 0.
- R11: A lane whose flag is 0 puts 8'h00 on its bits of `rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes take effect at its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears the array |
| chip_sel_n | input | 1 | Chip select, active low |
| chip_sel | input | 1 | Chip select, active high |
| out_en_n | input | 1 | Output enable, active low |
| wr_en_n | input | 1 | Write enable, active low |
| hi_byte_n | input | 1 | Upper byte (bits 15:8) enable, active low |
| lo_byte_n | input | 1 | Lower byte (bits 7:0) enable, active low |
| addr | input | ADDR_W (19) | Word address: page in bits 18:4, word in bits 3:0 |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, zero on lanes not driven |
| rdata_en | output | 2 | Per-lane drive flag (bit 0 lower, bit 1 upper) |

## Verification
Two functions can meet in one cycle. The first is the write committed at a clock edge. The second is a read of the same address in the very next cycle, which must already return the new byte on the written lane and the old byte on the lane that was masked. The stimulus table places write vectors directly before read vectors at the same address, with lower-only and upper-only writes between them. Each read result is judged against the byte-by-byte merge of the earlier writes, worked out by hand. A checker property also compares every such read-after-write with the data sampled on the write edge.

// File: rtl/sram_pkg.sv
package sram_pkg;

    localparam int LANE_W    = 8;
    localparam int LANES     = 2;
    localparam int DATA_W    = LANE_W * LANES;
    localparam int WORD_BITS = 4;
    localparam int PAGE_WORDS = 1 << WORD_BITS;

    typedef enum logic [1:0] {
        MODE_STANDBY = 2'd0,
        MODE_WRITE   = 2'd1,
        MODE_READ    = 2'd2,
        MODE_OUTOFF  = 2'd3
    } sram_mode_e;

endpackage

// File: rtl/sram_mode_decode.sv
module sram_mode_decode
    import sram_pkg::*;
(
    input  logic             chip_sel_n,
    input  logic             chip_sel,
    input  logic             out_en_n,
    input  logic             wr_en_n,
    input  logic             hi_byte_n,
    input  logic             lo_byte_n,
    output sram_mode_e       mode,
    output logic [LANES-1:0] lane_sel
);

    logic chip_on;
    logic any_lane;

    assign chip_on  = !chip_sel_n && chip_sel;
    assign any_lane = !(hi_byte_n && lo_byte_n);

    always_comb begin
        mode = MODE_STANDBY;
        if (chip_on && any_lane) begin
            unique casez ({wr_en_n, out_en_n})
                2'b0?:   mode = MODE_WRITE;
                2'b10:   mode = MODE_READ;
                2'b11:   mode = MODE_OUTOFF;
                default: mode = MODE_STANDBY;
            endcase
        end
    end

    assign lane_sel = {!hi_byte_n, !lo_byte_n};

endmodule

// File: rtl/sram_addr_split.sv
module sram_addr_split
    import sram_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int DEPTH  = 64
) (
    input  logic [ADDR_W-1:0]        addr,
    output logic [$clog2(DEPTH)-1:0] index
);

    localparam int IDX_W   = $clog2(DEPTH);
    localparam int PAGE_W  = ADDR_W - WORD_BITS;
    localparam int KEEP_W  = IDX_W - WORD_BITS;

    logic [WORD_BITS-1:0] word;
    logic [PAGE_W-1:0]    page;

    assign word = addr[WORD_BITS-1:0];
    assign page = addr[ADDR_W-1:WORD_BITS];

    generate
        if (KEEP_W == 0) begin : g_one_page
            logic page_unused;
            assign page_unused = ^page;
            assign index = word;
        end else if (KEEP_W < PAGE_W) begin : g_alias_pages
            logic page_hi_unused;
            assign page_hi_unused = ^page[PAGE_W-1:KEEP_W];
            assign index = {page[KEEP_W-1:0], word};
        end else begin : g_full_pages
            assign index = {page, word};
        end
    endgenerate

endmodule

// File: rtl/sram_byte_lane.sv
module sram_byte_lane
    import sram_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_stb,
    input  logic [$clog2(DEPTH)-1:0] index,
    input  logic [LANE_W-1:0]        wbyte,
    output logic [LANE_W-1:0]        rbyte
);

    logic [LANE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= '0;
            end
        end else if (wr_stb) begin
            cells[index] <= wbyte;
        end
    end

    assign rbyte = cells[index];

endmodule

// File: rtl/sram_dual_enable.sv
module sram_dual_enable
    import sram_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int DEPTH  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chip_sel_n,
    input  logic              chip_sel,
    input  logic              out_en_n,
    input  logic              wr_en_n,
    input  logic              hi_byte_n,
    input  logic              lo_byte_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       wdata,
    output logic [15:0]       rdata,
    output logic [1:0]        rdata_en
);

    localparam int IDX_W = $clog2(DEPTH);

    sram_mode_e          mode;
    logic [LANES-1:0]    lane_sel;
    logic [IDX_W-1:0]    index;
    logic [DATA_W-1:0]   stored;
    logic [LANES-1:0]    wr_lane;

    sram_mode_decode i_decode (
        .chip_sel_n (chip_sel_n),
        .chip_sel   (chip_sel),
        .out_en_n   (out_en_n),
        .wr_en_n    (wr_en_n),
        .hi_byte_n  (hi_byte_n),
        .lo_byte_n  (lo_byte_n),
        .mode       (mode),
        .lane_sel   (lane_sel)
    );

    sram_addr_split #(
        .ADDR_W (ADDR_W),
        .DEPTH  (DEPTH)
    ) i_split (
        .addr   (addr),
        .index  (index)
    );

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            assign wr_lane[l] = (mode == MODE_WRITE) && lane_sel[l];

            sram_byte_lane #(
                .DEPTH (DEPTH)
            ) i_lane (
                .clk    (clk),
                .rst_n  (rst_n),
                .wr_stb (wr_lane[l]),
                .index  (index),
                .wbyte  (wdata[l*LANE_W +: LANE_W]),
                .rbyte  (stored[l*LANE_W +: LANE_W])
            );
        end
    endgenerate

    always_comb begin
        rdata_en = '0;
        rdata    = '0;
        unique case (mode)
            MODE_READ: begin
                for (int l = 0; l < LANES; l++) begin
                    rdata_en[l] = lane_sel[l];
                    if (lane_sel[l]) begin
                        rdata[l*LANE_W +: LANE_W] = stored[l*LANE_W +: LANE_W];
                    end
                end
            end
            MODE_WRITE, MODE_OUTOFF, MODE_STANDBY: begin
                rdata_en = '0;
                rdata    = '0;
            end
            default: begin
                rdata_en = '0;
                rdata    = '0;
            end
        endcase
    end

endmodule

// File: rtl/sram_dual_enable_chk.sv
module sram_dual_enable_chk #(
    parameter int ADDR_W = 19
) (
    input logic              clk,
    input logic              rst_n,
    input logic              chip_sel_n,
    input logic              chip_sel,
    input logic              out_en_n,
    input logic              wr_en_n,
    input logic              hi_byte_n,
    input logic              lo_byte_n,
    input logic [ADDR_W-1:0] addr,
    input logic [15:0]       wdata,
    input logic [15:0]       rdata,
    input logic [1:0]        rdata_en
);

    logic past_ok;
    logic picked;
    logic rd_now;
    logic wr_lo;
    logic wr_hi;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assign picked = !chip_sel_n && chip_sel && !(hi_byte_n && lo_byte_n);
    assign rd_now = picked && wr_en_n && !out_en_n;
    assign wr_lo  = picked && !wr_en_n && !lo_byte_n;
    assign wr_hi  = picked && !wr_en_n && !hi_byte_n;

    AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_sel_n || !chip_sel) |-> (rdata_en == 2'b00)); // R1

    AST_BYTES_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_byte_n && lo_byte_n) |-> (rdata_en == 2'b00)); // R2

    AST_LANE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        ((rdata_en[0] -> !lo_byte_n) && (rdata_en[1] -> !hi_byte_n))); // R3

    AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (!chip_sel_n && chip_sel && !wr_en_n) |-> (rdata_en == 2'b00)); // R4

    AST_OE_HIGH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_n && out_en_n) |-> (rdata_en == 2'b00)); // R7

    AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        rd_now |-> (rdata_en == {!hi_byte_n, !lo_byte_n})); // R6

    AST_LO_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && rd_now && !lo_byte_n && $past(wr_lo) && (addr == $past(addr)))
        |-> (rdata[7:0] == $past(wdata[7:0]))); // R6

    AST_HI_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && rd_now && !hi_byte_n && $past(wr_hi) && (addr == $past(addr)))
        |-> (rdata[15:8] == $past(wdata[15:8]))); // R6

    AST_UNDRIVEN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((!rdata_en[0] -> (rdata[7:0] == 8'h00)) &&
         (!rdata_en[1] -> (rdata[15:8] == 8'h00)))); // R11

endmodule

bind sram_dual_enable sram_dual_enable_chk #(
    .ADDR_W (ADDR_W)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .chip_sel_n (chip_sel_n),
    .chip_sel   (chip_sel),
    .out_en_n   (out_en_n),
    .wr_en_n    (wr_en_n),
    .hi_byte_n  (hi_byte_n),
    .lo_byte_n  (lo_byte_n),
    .addr       (addr),
    .wdata      (wdata),
    .rdata      (rdata),
    .rdata_en   (rdata_en)
);

// File: tb/test_sram_dual_enable.sv
module test_sram_dual_enable;

    localparam int CLK_P  = 10;
    localparam int NVEC   = 16;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        chip_sel_n, chip_sel, out_en_n, wr_en_n, hi_byte_n, lo_byte_n;
    logic [18:0] addr;
    logic [15:0] wdata;
    logic [15:0] rdata;
    logic [1:0]  rdata_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_P/2) clk = ~clk;

    sram_dual_enable i_sram_dual_enable (
        .clk        (clk),
        .rst_n      (rst_n),
        .chip_sel_n (chip_sel_n),
        .chip_sel   (chip_sel),
        .out_en_n   (out_en_n),
        .wr_en_n    (wr_en_n),
        .hi_byte_n  (hi_byte_n),
        .lo_byte_n  (lo_byte_n),
        .addr       (addr),
        .wdata      (wdata),
        .rdata      (rdata),
        .rdata_en   (rdata_en)
    );

    // vector: {chip_sel_n, chip_sel, wr_en_n, out_en_n, hi_byte_n, lo_byte_n},
    //         addr, wdata, expected rdata_en, expected rdata, requirement number
    localparam logic [62:0] VEC [NVEC] = '{
        {6'b010000, 19'h00003, 16'hA1B2, 2'b00, 16'h0000, 4'd4},  // R4 write both, oe low ignored
        {6'b011000, 19'h00003, 16'h0000, 2'b11, 16'hA1B2, 4'd6},  // R6 read right after write
        {6'b010010, 19'h00003, 16'hFFCC, 2'b00, 16'h0000, 4'd5},  // R5 lower-only write
        {6'b011000, 19'h00003, 16'h0000, 2'b11, 16'hA1CC, 4'd5},  // R5 upper byte kept
        {6'b010101, 19'h00003, 16'h5566, 2'b00, 16'h0000, 4'd4},  // R4 upper-only write, oe high
        {6'b011010, 19'h00003, 16'h0000, 2'b01, 16'h00CC, 4'd3},  // R3 R11 lower lane read
        {6'b011001, 19'h00003, 16'h0000, 2'b10, 16'h5500, 4'd3},  // R3 R11 upper lane read
        {6'b110000, 19'h00003, 16'h0000, 2'b00, 16'h0000, 4'd1},  // R1 first select high
        {6'b000000, 19'h00003, 16'h0000, 2'b00, 16'h0000, 4'd1},  // R1 second select low
        {6'b010011, 19'h00003, 16'h0000, 2'b00, 16'h0000, 4'd2},  // R2 both bytes off
        {6'b011000, 19'h00003, 16'h0000, 2'b11, 16'h55CC, 4'd8},  // R8 standby writes dropped
        {6'b011100, 19'h00003, 16'h0000, 2'b00, 16'h0000, 4'd7},  // R7 output disabled
        {6'b010000, 19'h00017, 16'h1234, 2'b00, 16'h0000, 4'd4},  // R4 page 1 word 7
        {6'b011000, 19'h00057, 16'h0000, 2'b11, 16'h1234, 4'd9},  // R9 page 5 aliases page 1
        {6'b011000, 19'h00007, 16'h0000, 2'b11, 16'h0000, 4'd9},  // R9 other page
        {6'b011000, 19'h00013, 16'h0000, 2'b11, 16'h0000, 4'd9}   // R9 other word
    };

    task automatic drive(input logic [5:0] c, input logic [18:0] a, input logic [15:0] d);
        {chip_sel_n, chip_sel, wr_en_n, out_en_n, hi_byte_n, lo_byte_n} = c;
        addr  = a;
        wdata = d;
    endtask

    task automatic check(input int req, input logic [1:0] exp_en, input logic [15:0] exp_d);
        checks++;
        if (rdata_en !== exp_en || rdata !== exp_d) begin
            fails++;
            $display("FAIL R%0d: rdata_en=%b rdata=%h expected rdata_en=%b rdata=%h",
                     req, rdata_en, rdata, exp_en, exp_d);
        end
    endtask

    task automatic step(input logic [5:0] c, input logic [18:0] a, input logic [15:0] d,
                        input int req, input logic [1:0] exp_en, input logic [15:0] exp_d);
        @(negedge clk);
        drive(c, a, d);
        #1;
        check(req, exp_en, exp_d);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        drive(6'b110000, 19'h0, 16'h0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R10: array reads as zero after reset
        step(6'b011000, 19'h00003, 16'h0, 10, 2'b11, 16'h0000);

        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][62:57], VEC[i][56:38], VEC[i][37:22],
                 int'(VEC[i][3:0]), VEC[i][21:20], VEC[i][19:4]);
        end

        // R9: highest address lands on the last word, reached again through an alias
        step(6'b010000, 19'h7FFFF, 16'hDEAD, 9, 2'b00, 16'h0000);
        step(6'b011000, 19'h0003F, 16'h0000, 9, 2'b11, 16'hDEAD);

        // R8: standby with write enable low and a new address leaves the word alone
        step(6'b000000, 19'h0003F, 16'h0BAD, 8, 2'b00, 16'h0000);
        step(6'b011000, 19'h0003F, 16'h0000, 8, 2'b11, 16'hDEAD);

        // R10: reset in mid-run clears written words
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        step(6'b011000, 19'h00017, 16'h0000, 10, 2'b11, 16'h0000);
        step(6'b011000, 19'h00003, 16'h0000, 10, 2'b11, 16'h0000);

        finish_run();
    end

endmodule